// File: doc/BRIEF.md
# Dual-Bank CPU Register File with Bank Exchange

This block is the general register storage of an 8-bit processor core. It holds an accumulator, a flag register and six general registers. The six general registers are grouped as three 16-bit pairs. Every one of these registers has a primary copy and an alternate copy.

Two select bits choose which copy is visible. One select covers the accumulator and flags together. The other covers the six general registers as a group. Two exchange inputs each flip one select bit, so switching banks moves no data.

Decode logic reads and writes the visible copy in two ways. Byte access uses a register index. Pair access uses a pair index and is 16 bits wide. The first register of a pair supplies the upper byte. A separate port writes the flags, for use by an ALU.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset both selects choose the primary bank, and every register in both banks reads zero.
- R2: Byte access uses these register indices: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A. A write takes effect at the clock edge and changes only the active copy. Reads are combinational from the active copy. Index 6 names no register: a write to index 6 changes nothing, and a read of index 6 returns zero.
- R3: Pair access uses these pair indices: 0=BC, 1=DE, 2=HL, 3=A with F. Bits 15:8 of a pair hold the first-named register and bits 7:0 hold the second. A pair write updates both bytes at the same clock edge.
- R4: The flag port writes the active F at the clock edge. flags_out always shows the active F.
- R5: A pulse on xchg_af swaps A and F to the other bank together and leaves B through L untouched. A second pulse brings the original A and F back.
- R6: A pulse on xchg_gp swaps B, C, D, E, H and L to the other bank as a group and leaves A and F untouched.
- R7: When a write and an exchange fall in the same cycle, the write lands in the bank that was active before the toggle.
- R8: When several writes target the same byte in one cycle, a byte-indexed write beats a pair write, and a flag port write beats a pair write to F.
- R9: Pulsing both exchange inputs in the same cycle toggles both selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xchg_af | input | 1 | Toggle the accumulator/flag bank select |
| xchg_gp | input | 1 | Toggle the general-pair bank select |
| wr8_en | input | 1 | Byte write enable |
| wr8_idx | input | 3 | Byte write register index |
| wr8_data | input | DW | Byte write data |
| rd8_idx | input | 3 | Byte read register index |
| rd8_data | output | DW | Byte read data |
| wr16_en | input | 1 | Pair write enable |
| wr16_idx | input | 2 | Pair write index |
| wr16_data | input | 2*DW | Pair write data, high byte to the first register |
| rd16_idx | input | 2 | Pair read index |
| rd16_data | output | 2*DW | Pair read data |
| fwr_en | input | 1 | Flag port write enable |
| fwr_data | input | DW | Flag port write data |
| flags_out | output | DW | Active flag register |

## Verification
A write and an exchange can meet in one cycle. So can two writes to the same byte. The bench provokes the first case with two write types in turn: a byte write to A under xchg_af, and a pair write to DE under xchg_gp. It judges the result by reading both banks afterwards: the new value must sit in the bank that was active before the toggle, and the other bank must still hold its old value. It provokes the second case by sending a byte write and a pair write to one pair in the same cycle, and a flag port write with a pair write to A and F. It then checks which value each byte kept.

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xchg_af,
  input  logic            xchg_gp,
  input  logic            wr8_en,
  input  logic [2:0]      wr8_idx,
  input  logic [DW-1:0]   wr8_data,
  input  logic [2:0]      rd8_idx,
  output logic [DW-1:0]   rd8_data,
  input  logic            wr16_en,
  input  logic [1:0]      wr16_idx,
  input  logic [2*DW-1:0] wr16_data,
  input  logic [1:0]      rd16_idx,
  output logic [2*DW-1:0] rd16_data,
  input  logic            fwr_en,
  input  logic [DW-1:0]   fwr_data,
  output logic [DW-1:0]   flags_out
);
  localparam int PW    = 2 * DW;
  localparam int NGP   = 6;
  localparam int NBANK = 2;

  logic          af_sel, gp_sel;
  logic [DW-1:0] gp_q  [NBANK][NGP];
  logic [DW-1:0] acc_q [NBANK];
  logic [DW-1:0] flg_q [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_sel <= 1'b0;
      gp_sel <= 1'b0;
      for (int b = 0; b < NBANK; b++) begin
        acc_q[b] <= '0;
        flg_q[b] <= '0;
        for (int k = 0; k < NGP; k++) gp_q[b][k] <= '0;
      end
    end else begin
      for (int k = 0; k < NGP; k++) begin
        if (wr16_en && wr16_idx == 2'(k >> 1))
          gp_q[gp_sel][k] <= (k % 2 == 0) ? wr16_data[PW-1:DW] : wr16_data[DW-1:0];
        if (wr8_en && wr8_idx == 3'(k))
          gp_q[gp_sel][k] <= wr8_data;
      end
      if (wr16_en && wr16_idx == 2'd3) begin
        acc_q[af_sel] <= wr16_data[PW-1:DW];
        flg_q[af_sel] <= wr16_data[DW-1:0];
      end
      if (wr8_en && wr8_idx == 3'd7) acc_q[af_sel] <= wr8_data;
      if (fwr_en) flg_q[af_sel] <= fwr_data;
      af_sel <= af_sel ^ xchg_af;
      gp_sel <= gp_sel ^ xchg_gp;
    end
  end

  always_comb begin
    case (rd8_idx)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5: rd8_data = gp_q[gp_sel][rd8_idx];
      3'd7:    rd8_data = acc_q[af_sel];
      default: rd8_data = '0;
    endcase
  end

  always_comb begin
    case (rd16_idx)
      2'd0:    rd16_data = {gp_q[gp_sel][0], gp_q[gp_sel][1]};
      2'd1:    rd16_data = {gp_q[gp_sel][2], gp_q[gp_sel][3]};
      2'd2:    rd16_data = {gp_q[gp_sel][4], gp_q[gp_sel][5]};
      default: rd16_data = {acc_q[af_sel], flg_q[af_sel]};
    endcase
  end

  assign flags_out = flg_q[af_sel];

  a_r3_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_en && wr16_idx != 2'd3 && !wr8_en && !xchg_gp) |=>
    (rd16_idx != $past(wr16_idx) || rd16_data == $past(wr16_data)));

  a_r4_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fwr_en && !xchg_af) |=> flags_out == $past(fwr_data));

  a_r5_af_xchg_keeps_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_af && !xchg_gp && !wr8_en && !wr16_en && rd16_idx != 2'd3) |=>
    (!$stable(rd16_idx) || $stable(rd16_data)));

  a_r6_gp_xchg_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_gp && !xchg_af && !wr16_en && !fwr_en) |=> $stable(flags_out));

  a_r2_idx6_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd8_idx == 3'd6) |-> rd8_data == '0);
endmodule

// File: tb/sim_dual_bank_regfile.sv
module sim_dual_bank_regfile;
  logic clk = 0, rst_n = 0;
  logic xchg_af = 0, xchg_gp = 0, wr8_en = 0, wr16_en = 0, fwr_en = 0;
  logic [2:0] wr8_idx = 0, rd8_idx = 0;
  logic [7:0] wr8_data = 0, fwr_data = 0, rd8_data, flags_out;
  logic [1:0] wr16_idx = 0, rd16_idx = 0;
  logic [15:0] wr16_data = 0, rd16_data;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [7:0] m_gp [2][6];
  logic [7:0] m_a [2];
  logic [7:0] m_f [2];
  bit s_af = 0, s_gp = 0;

  always #5 clk = ~clk;

  dual_bank_regfile #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .xchg_af(xchg_af), .xchg_gp(xchg_gp),
    .wr8_en(wr8_en), .wr8_idx(wr8_idx), .wr8_data(wr8_data),
    .rd8_idx(rd8_idx), .rd8_data(rd8_data),
    .wr16_en(wr16_en), .wr16_idx(wr16_idx), .wr16_data(wr16_data),
    .rd16_idx(rd16_idx), .rd16_data(rd16_data),
    .fwr_en(fwr_en), .fwr_data(fwr_data), .flags_out(flags_out));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(bit xa, bit xg, bit w8, logic [2:0] i8, logic [7:0] d8,
                       bit w16, logic [1:0] i16, logic [15:0] d16, bit wf, logic [7:0] df);
    @(negedge clk);
    xchg_af = xa; xchg_gp = xg;
    wr8_en = w8; wr8_idx = i8; wr8_data = d8;
    wr16_en = w16; wr16_idx = i16; wr16_data = d16;
    fwr_en = wf; fwr_data = df;
    if (w16) begin
      if (i16 == 3) begin m_a[s_af] = d16[15:8]; m_f[s_af] = d16[7:0]; end
      else begin m_gp[s_gp][2*i16] = d16[15:8]; m_gp[s_gp][2*i16+1] = d16[7:0]; end
    end
    if (w8) begin
      if (i8 == 7) m_a[s_af] = d8;
      else if (i8 != 6) m_gp[s_gp][i8] = d8;
    end
    if (wf) m_f[s_af] = df;
    s_af ^= xa; s_gp ^= xg;
    @(posedge clk); #2;
    xchg_af = 0; xchg_gp = 0; wr8_en = 0; wr16_en = 0; fwr_en = 0;
  endtask

  task automatic chk_all(string tag);
    for (int i = 0; i < 8; i++) begin
      rd8_idx = 3'(i); #1;
      if (i == 7) check({tag, " A"}, {8'h0, rd8_data}, {8'h0, m_a[s_af]});
      else if (i == 6) check({tag, " idx6"}, {8'h0, rd8_data}, 16'h0);
      else check({tag, " reg"}, {8'h0, rd8_data}, {8'h0, m_gp[s_gp][i]});
    end
    for (int p = 0; p < 4; p++) begin
      rd16_idx = 2'(p); #1;
      if (p == 3) check({tag, " pairAF"}, rd16_data, {m_a[s_af], m_f[s_af]});
      else check({tag, " pair"}, rd16_data, {m_gp[s_gp][2*p], m_gp[s_gp][2*p+1]});
    end
    check({tag, " flags"}, {8'h0, flags_out}, {8'h0, m_f[s_af]});
  endtask

  task automatic t_reset;
    for (int b = 0; b < 2; b++) begin
      m_a[b] = 0; m_f[b] = 0;
      for (int k = 0; k < 6; k++) m_gp[b][k] = 0;
    end
    chk_all("R1 reset bank0");
    apply(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R1 reset bank1");
    apply(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 6; i++) apply(0, 0, 1, 3'(i), 8'h10 + 8'(i), 0, 0, 0, 0, 0);
    apply(0, 0, 1, 7, 8'hA0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hF0);
    chk_all("R2 R4 fill bank0");
    apply(0, 0, 0, 0, 0, 1, 2, 16'h4455, 0, 0);
    rd8_idx = 4; #1; check("R3 H high byte", {8'h0, rd8_data}, 16'h0044);
    rd8_idx = 5; #1; check("R3 L low byte", {8'h0, rd8_data}, 16'h0055);
    apply(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R9 both xchg to bank1");
    for (int p = 0; p < 3; p++) apply(0, 0, 0, 0, 0, 1, 2'(p), 16'h2021 + 16'(p) * 16'h0202, 0, 0);
    apply(0, 0, 0, 0, 0, 1, 3, 16'hB10F, 0, 0);
    chk_all("R3 fill bank1");
  endtask

  task automatic t_xaf;
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R5 af xchg once");
    rd8_idx = 7; #1; check("R5 A now primary", {8'h0, rd8_data}, 16'h00A0);
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R5 af xchg twice");
  endtask

  task automatic t_xgp;
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R6 gp xchg once");
    rd16_idx = 0; #1; check("R6 BC now primary", rd16_data, 16'h1011);
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R6 gp xchg twice");
  endtask

  task automatic t_same;
    apply(1, 0, 1, 7, 8'h5C, 0, 0, 0, 0, 0);
    chk_all("R7 after xchg+write A");
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd8_idx = 7; #1; check("R7 A in old bank", {8'h0, rd8_data}, 16'h005C);
    apply(0, 1, 0, 0, 0, 1, 1, 16'h9876, 0, 0);
    chk_all("R7 after xchg+pair write");
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    rd16_idx = 1; #1; check("R7 DE in old bank", rd16_data, 16'h9876);
    chk_all("R7 final");
  endtask

  task automatic t_prio;
    apply(0, 0, 1, 1, 8'h77, 1, 0, 16'h1234, 0, 0);
    rd16_idx = 0; #1; check("R8 byte beats pair", rd16_data, 16'h1277);
    apply(0, 0, 0, 0, 0, 1, 3, 16'hBEEF, 1, 8'h5A);
    rd16_idx = 3; #1; check("R8 flag port beats pair", rd16_data, 16'hBE5A);
    chk_all("R8 final");
  endtask

  task automatic t_idx6;
    apply(0, 0, 1, 6, 8'hEE, 0, 0, 0, 0, 0);
    chk_all("R2 idx6 write ignored");
    apply(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk_all("R2 idx6 other bank");
    apply(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #17 rst_n = 1;
    #10;
    t_reset;
    t_fill;
    t_xaf;
    t_xgp;
    t_same;
    t_prio;
    t_idx6;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule